// File: doc/BRIEF.md
# Peripheral Reset Pulse Controller

This block turns register writes into timed, active-high reset pulses for thirteen peripheral domains and for the CPU core. Software writes a 1 into a request bit of one of two 32-bit control words. The matching reset line goes high for a fixed number of clocks. The request bit reads back as 1 for that whole interval and then clears itself, so software can poll for completion.

Besides the per-domain requests there are three grouped requests. Each one drives the union of its member lines:
- **Peripheral group:** every domain except the watchdog and GPIO.
- **Soft group:** the peripheral group plus GPIO.
- **System group:** every domain plus the CPU line.

Every request channel has its own timer, so several pulses can run and overlap. The block's own state is cleared only by the power-on reset input. No reset that the block generates clears its own state.

Top module: `periph_reset_ctrl`

## Requirements
- R1: While `por_n` is low, every reset output is 0 and both control words read 0. Asserting `por_n` low in the middle of a pulse ends that pulse at once.
- R2: A write of 1 to an idle individual request bit drives only that domain's line in `rst_dom` high, for exactly PULSE_LEN cycles (default 8), starting the cycle after the write.
- R3: A read of a request bit returns 1 while its pulse is active and 0 once it has ended.
- R4: Writing 1 to a request bit whose pulse is already active is ignored, and the pulse is not lengthened.
- R5: Writing 0 to a request bit has no effect. Bits with no request assigned read as 0, and writing to them does nothing.
- R6: The peripheral group (word A bit 30) drives every domain line except watchdog (index 1) and GPIO (index 2), and leaves `rst_cpu` low.
- R7: The soft group (word A bit 29) drives the peripheral group's lines plus GPIO, and leaves watchdog and `rst_cpu` low.
- R8: The system group (word A bit 31) drives every domain line and `rst_cpu`.
- R9: Word A sits at address 0x04 and word B at 0x44. Word B bit 0 is the I2C1 request, which drives domain index 11. A write to any other address is ignored.
- R10: Word A bit positions and their domain indices are: DMA bit 0 (index 0), watchdog bit 1 (1), GPIO bit 2 (2), timers 0–2 bits 5–7 (3–5), UART0 bit 11 (6), UART1 bit 12 (7), SPI0 bit 13 (8), SPI1 bit 14 (9), I2C0 bit 16 (10), RTC bit 17 (12).
- R11: Each channel times its pulse independently. A system pulse started while another pulse is running does not clear, restart or lengthen that other pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, valid in the same cycle |
| rst_dom | output | 13 | Active-high reset line for each peripheral domain |
| rst_cpu | output | 1 | Active-high CPU core reset |

## Verification
The hardest situation to reach is two pulses of different channels overlapping with a known phase offset. In that case one channel's line or busy bit must fall while a larger group pulse that also covers it keeps running. The `rst_dom` port alone cannot show this, because the group holds the shared line high. The bench therefore starts a UART0 pulse and, three cycles later, a system pulse. It then reads word A on the exact cycle where the UART0 bit must drop, while the system bit is still set. The same cycle-counting approach drives a second write into an already active pulse mid-flight, to show that the pulse end does not move.

// File: rtl/prc_pkg.sv
package prc_pkg;
   localparam int unsigned NUM_DOM  = 13;
   localparam int unsigned NUM_CHAN = 16;

   // channel index == domain index for the individual requests
   localparam int unsigned CH_DMA    = 0;
   localparam int unsigned CH_WDT    = 1;
   localparam int unsigned CH_GPIO   = 2;
   localparam int unsigned CH_I2C1   = 11;
   localparam int unsigned CH_PERIPH = 13;
   localparam int unsigned CH_SOFT   = 14;
   localparam int unsigned CH_SYS    = 15;

   // bit position of every channel in word A (I2C1 lives in word B)
   localparam int unsigned POS_A [NUM_CHAN] =
      '{0, 1, 2, 5, 6, 7, 11, 12, 13, 14, 16, 0, 17, 30, 29, 31};
   localparam int unsigned POS_B_I2C1 = 0;

   localparam logic [NUM_DOM-1:0] SOFT_MASK   =
      {NUM_DOM{1'b1}} ^ (NUM_DOM'(1) << CH_WDT);
   localparam logic [NUM_DOM-1:0] PERIPH_MASK =
      SOFT_MASK ^ (NUM_DOM'(1) << CH_GPIO);
endpackage

// File: rtl/prc_pulse_timer.sv
module prc_pulse_timer #(
   parameter int unsigned PULSE_LEN = 8
) (
   input  logic clk,
   input  logic por_n,
   input  logic start,
   output logic busy
);
   localparam int unsigned CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         busy   <= 1'b0;
         remain <= '0;
      end else if (!busy) begin
         if (start) begin
            busy   <= 1'b1;
            remain <= CW'(PULSE_LEN - 1);
         end
      end else if (remain == '0) begin
         busy <= 1'b0;
      end else begin
         remain <= remain - 1'b1;
      end
   end
endmodule

// File: rtl/prc_regs.sv
module prc_regs
   import prc_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned OFF_A  = 'h04,
   parameter int unsigned OFF_B  = 'h44
) (
   input  logic                bus_sel,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   input  logic [NUM_CHAN-1:0] busy,
   output logic [NUM_CHAN-1:0] start,
   output logic [31:0]         bus_rdata
);
   logic hit_a, hit_b;

   assign hit_a = bus_sel && (bus_addr == ADDR_W'(OFF_A));
   assign hit_b = bus_sel && (bus_addr == ADDR_W'(OFF_B));

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_start
      if (c == CH_I2C1) begin : g_word_b
         assign start[c] = hit_b && bus_we && bus_wdata[POS_B_I2C1];
      end else begin : g_word_a
         assign start[c] = hit_a && bus_we && bus_wdata[POS_A[c]];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_a && !bus_we) begin
         for (int c = 0; c < NUM_CHAN; c++) begin
            if (c != CH_I2C1) bus_rdata[POS_A[c]] = busy[c];
         end
      end
      if (hit_b && !bus_we) bus_rdata[POS_B_I2C1] = busy[CH_I2C1];
   end
endmodule

// File: rtl/prc_fanout.sv
module prc_fanout
   import prc_pkg::*;
(
   input  logic [NUM_CHAN-1:0] busy,
   output logic [NUM_DOM-1:0]  rst_dom,
   output logic                rst_cpu
);
   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      assign rst_dom[d] = busy[d] | busy[CH_SYS]
                        | (PERIPH_MASK[d] & busy[CH_PERIPH])
                        | (SOFT_MASK[d]   & busy[CH_SOFT]);
   end
   assign rst_cpu = busy[CH_SYS];
endmodule

// File: rtl/periph_reset_ctrl.sv
module periph_reset_ctrl
   import prc_pkg::*;
#(
   parameter int unsigned PULSE_LEN = 8,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned OFF_A     = 'h04,
   parameter int unsigned OFF_B     = 'h44
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic [NUM_DOM-1:0] rst_dom,
   output logic               rst_cpu
);
   if (PULSE_LEN < 1) begin : g_bad_len
      $error("PULSE_LEN must be at least 1");
   end
   if (OFF_A == OFF_B || (OFF_A % 4) != 0 || (OFF_B % 4) != 0) begin : g_bad_off
      $error("word offsets must differ and be word aligned");
   end
   if (OFF_A >= (1 << ADDR_W) || OFF_B >= (1 << ADDR_W)) begin : g_bad_aw
      $error("ADDR_W too narrow for the word offsets");
   end

   logic [NUM_CHAN-1:0] start;
   logic [NUM_CHAN-1:0] busy;

   prc_regs #(.ADDR_W(ADDR_W), .OFF_A(OFF_A), .OFF_B(OFF_B)) u_regs (
      .bus_sel  (bus_sel),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .busy     (busy),
      .start    (start),
      .bus_rdata(bus_rdata)
   );

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      prc_pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_tmr (
         .clk  (clk),
         .por_n(por_n),
         .start(start[c]),
         .busy (busy[c])
      );
   end

   prc_fanout u_fan (
      .busy   (busy),
      .rst_dom(rst_dom),
      .rst_cpu(rst_cpu)
   );
endmodule

// File: rtl/periph_reset_ctrl_chk.sv
module periph_reset_ctrl_chk
   import prc_pkg::*;
#(
   parameter int unsigned PULSE_LEN = 8,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned OFF_A     = 'h04,
   parameter int unsigned OFF_B     = 'h44
) (
   input logic               clk,
   input logic               por_n,
   input logic               bus_sel,
   input logic               bus_we,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [31:0]        bus_wdata,
   input logic [31:0]        bus_rdata,
   input logic [NUM_DOM-1:0] rst_dom,
   input logic               rst_cpu,
   input logic [NUM_CHAN-1:0] busy
);
   logic wr_a, rd_a;
   logic [31:0] cpu_run;

   assign wr_a = bus_sel && bus_we  && (bus_addr == ADDR_W'(OFF_A));
   assign rd_a = bus_sel && !bus_we && (bus_addr == ADDR_W'(OFF_A));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       cpu_run <= '0;
      else if (rst_cpu) cpu_run <= cpu_run + 1;
      else              cpu_run <= '0;
   end

   a_r2_dma_start: assert property (@(posedge clk) disable iff (!por_n)
      (wr_a && bus_wdata[0] && !busy[CH_DMA]) |=> busy[CH_DMA]);

   a_r5_zero_write: assert property (@(posedge clk) disable iff (!por_n)
      (wr_a && !bus_wdata[0] && !busy[CH_DMA]) |=> !busy[CH_DMA]);

   a_r4_no_stretch: assert property (@(posedge clk) disable iff (!por_n)
      cpu_run <= PULSE_LEN);

   a_r6_wdt_spared: assert property (@(posedge clk) disable iff (!por_n)
      rst_dom[CH_WDT] |-> (busy[CH_WDT] || busy[CH_SYS]));

   a_r7_soft_gpio: assert property (@(posedge clk) disable iff (!por_n)
      busy[CH_SOFT] |-> rst_dom[CH_GPIO]);

   a_r8_sys_all: assert property (@(posedge clk) disable iff (!por_n)
      rst_cpu |-> (&rst_dom));

   a_r3_readback: assert property (@(posedge clk) disable iff (!por_n)
      rd_a |-> (bus_rdata[31] == rst_cpu));
endmodule

bind periph_reset_ctrl periph_reset_ctrl_chk #(
   .PULSE_LEN(PULSE_LEN), .ADDR_W(ADDR_W), .OFF_A(OFF_A), .OFF_B(OFF_B)
) u_chk (
   .clk      (clk),
   .por_n    (por_n),
   .bus_sel  (bus_sel),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .rst_dom  (rst_dom),
   .rst_cpu  (rst_cpu),
   .busy     (busy)
);

// File: tb/periph_reset_ctrl_bench.sv
module periph_reset_ctrl_bench;
   localparam int PLEN = 8;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [12:0] rst_dom;
   logic        rst_cpu;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   periph_reset_ctrl u_periph_reset_ctrl (
      .clk(clk), .por_n(por_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rst_dom(rst_dom), .rst_cpu(rst_cpu)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // returns one negedge later, after the write edge
   task automatic wr(logic [7:0] a, logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 dom in por", 32'(rst_dom), 0);
      check("R1 cpu in por", 32'(rst_cpu), 0);
      @(negedge clk); por_n = 1'b1; @(negedge clk);
      rd(8'h04, v); check("R1 word A after por", v, 0);
      rd(8'h44, v); check("R1 word B after por", v, 0);
   endtask

   task automatic t_single(string req, int pos, int dom);
      logic [31:0] v;
      int n = 0;
      wr(8'h04, 32'd1 << pos);
      check({req, " line"}, 32'(rst_dom), 32'd1 << dom);
      check({req, " cpu"}, 32'(rst_cpu), 0);
      rd(8'h04, v); check({"R3 busy ", req}, v, 32'd1 << pos);
      while (rst_dom[dom] && n < 100) begin n++; @(negedge clk); end
      check({"R2 length ", req}, n, PLEN);
      rd(8'h04, v); check({"R3 done ", req}, v, 0);
   endtask

   task automatic t_group(string req, int pos, logic [12:0] mask, logic cpu);
      logic [31:0] v;
      int n = 0;
      wr(8'h04, 32'd1 << pos);
      check({req, " lines"}, 32'(rst_dom), 32'(mask));
      check({req, " cpu"}, 32'(rst_cpu), 32'(cpu));
      rd(8'h04, v); check({req, " busy"}, v, 32'd1 << pos);
      while (rst_dom[0] && n < 100) begin n++; @(negedge clk); end
      check({req, " length"}, n, PLEN);
   endtask

   task automatic t_rewrite();
      int n = 0;
      wr(8'h04, 32'h1);
      while (rst_dom[0] && n < 100) begin
         n++;
         if (n == 3) wr(8'h04, 32'h1); else @(negedge clk);
      end
      check("R4 rewrite ignored", n, PLEN);
   endtask

   task automatic t_zero();
      logic [31:0] v;
      wr(8'h04, 32'h0);
      check("R5 zero write", 32'(rst_dom), 0);
      wr(8'h04, 32'h1FFC_8718);
      check("R5 unlisted write", {19'd0, rst_dom}, 0);
      rd(8'h04, v); check("R5 unlisted read", v, 0);
   endtask

   task automatic t_wordb();
      logic [31:0] v;
      int n = 0;
      wr(8'h44, 32'h2);
      check("R9 word B bit1 ignored", 32'(rst_dom), 0);
      wr(8'h08, 32'hFFFF_FFFF);
      check("R9 other address", {18'd0, rst_cpu, rst_dom}, 0);
      wr(8'h44, 32'h1);
      check("R9 I2C1 line", 32'(rst_dom), 32'd1 << 11);
      rd(8'h44, v); check("R9 word B busy", v, 1);
      rd(8'h04, v); check("R9 word A quiet", v, 0);
      while (rst_dom[11] && n < 100) begin n++; @(negedge clk); end
      check("R9 I2C1 length", n, PLEN);
      rd(8'h44, v); check("R9 word B done", v, 0);
   endtask

   task automatic t_overlap();
      logic [31:0] v;
      wr(8'h04, 32'd1 << 11);              // sample 1
      @(negedge clk); @(negedge clk);      // sample 3
      wr(8'h04, 32'h8000_0000);            // sample 4
      repeat (4) @(negedge clk);           // sample 8
      rd(8'h04, v); check("R11 both busy", v, 32'h8000_0800);
      @(negedge clk);                      // sample 9
      rd(8'h04, v); check("R11 uart done, sys on", v, 32'h8000_0000);
      check("R11 cpu still held", 32'(rst_cpu), 1);
      repeat (10) @(negedge clk);
   endtask

   task automatic t_por_mid();
      logic [31:0] v;
      wr(8'h04, 32'h8000_0000);
      @(negedge clk);
      por_n = 1'b0; #1;
      check("R1 por ends pulse", {18'd0, rst_cpu, rst_dom}, 0);
      @(negedge clk); por_n = 1'b1; @(negedge clk);
      rd(8'h04, v); check("R1 por clears busy", v, 0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_single("R10 DMA", 0, 0);
      t_single("R10 WDT", 1, 1);
      t_single("R10 TMR2", 7, 5);
      t_single("R10 SPI1", 14, 9);
      t_single("R10 RTC", 17, 12);
      t_rewrite();
      t_zero();
      t_group("R6 periph", 30, 13'h1FF9, 1'b0);
      t_group("R7 soft", 29, 13'h1FFD, 1'b0);
      t_group("R8 system", 31, 13'h1FFF, 1'b1);
      t_wordb();
      t_overlap();
      t_por_mid();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule